// File: doc/BRIEF.md
# Wrapping Burst Read Stream Buffer

This block turns a byte-addressed memory into a sequential byte stream. A start pulse gives it an address and a block count. From then on it fetches 32-bit words ahead of the consumer over a simple request/grant/response port. The consumer can take one byte, a 16-bit half or a 32-bit word per cycle from the head of the stream. Wider reads are assembled little-endian and may start at any byte position, including across word boundaries.

When the block count is zero, the fetch address increases without limit. When it is nonzero, the stream covers a region of count × 64 bytes that begins at the start address. After the last byte of that region the stream continues at the first byte, so a program that loops over its region repeats with the same timing on every pass.

A new start pulse, for example on a branch, discards everything buffered or still in flight. The stream then refills from the new location.

Top module: `burst_stream_fifo`

## Requirements
- R1: While reset is asserted, and after reset until the first start pulse, `rd_ready_o` and `mem_req_o` are both 0.
- R2: After a start pulse the block requests word-aligned addresses, beginning at the start address rounded down to a multiple of 4 and rising by 4 per granted request. The first stream byte is the byte at the start address itself.
- R3: `rd_size_i` selects the read width: 0 is one byte, 1 is two bytes, 2 and 3 are four bytes. A read is taken in a cycle where `rd_req_i` and `rd_ready_o` are both 1. In `rd_data_o`, bits 7:0 hold the byte at the lowest address, the unused upper bits are 0, and the stream advances by the read width.
- R4: A read of any width may begin at any byte offset and span two fetched words.
- R5: `rd_ready_o` is 0 while fewer bytes are buffered than the selected width needs.
- R6: With a block count of 0, the stream continues through consecutive addresses and never wraps.
- R7: With a nonzero block count N, the byte after the last byte of the region is the first byte of the region. Every fetch address lies inside that region.
- R8: With a nonzero block count, the low two start-address bits are treated as 0, so the region and the stream begin at the word-aligned address.
- R9: A start pulse discards buffered and in-flight data, and a read requested in the start cycle is not taken. `rd_ready_o` is 0 in the cycle after the pulse, and all later reads come from the new address.
- R10: Buffered plus outstanding words never exceed 16. With no reads, exactly 16 requests are granted after a start.
- R11: A request that is not granted stays asserted with the same address in the next cycle unless a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart pulse |
| start_addr_i | input | AW | Byte start address |
| start_blocks_i | input | BLK_W | Region size in 64-byte blocks, 0 = linear |
| rd_req_i | input | 1 | Consumer read request |
| rd_size_i | input | 2 | Read width code |
| rd_ready_o | output | 1 | Enough bytes buffered for the requested width |
| rd_data_o | output | 32 | Little-endian read data, zero-extended |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | AW | Word-aligned fetch byte address |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Response word valid, in request order |
| mem_rdata_i | input | 32 | Response word |

## Verification
The bench uses the default parameters: 16-bit addresses, a 16-word buffer, 4-bit block counts and 16 words per block. It adds a three-stage memory response delay and a grant that drops every third cycle. Regions of one to three blocks (64 to 192 bytes) are small enough that runs of about a hundred mixed-width reads pass each wrap point several times. Those runs also fill and drain the buffer repeatedly and hit every byte alignment. The 16-word buffer makes the credit limit exactly countable after an idle wait, and the short response delay leaves stale responses in flight when a restart is issued.

// File: rtl/bstr_pkg.sv
package bstr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } rd_size_e;

    // number of stream bytes a read width code consumes
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (rd_size_e'(code))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bstr_fetch.sv
module bstr_fetch #(
    parameter int AW        = 16,
    parameter int DEPTH     = 16,
    parameter int BLK_W     = 4,
    parameter int BLK_LONGS = 16,
    localparam int LAW      = AW - 2,
    localparam int CNT_W    = $clog2(DEPTH) + 1,
    localparam int BL_SH    = $clog2(BLK_LONGS),
    localparam int RW       = BLK_W + BL_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LAW-1:0]   laddr_i,
    input  logic [BLK_W-1:0] blocks_i,
    input  logic [CNT_W-1:0] occ_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    output logic             keep_o,
    output logic [CNT_W-1:0] inflight_o
);

    typedef struct packed {
        logic             active;
        logic [LAW-1:0]   base;
        logic [LAW-1:0]   cur;
        logic [RW-1:0]    len;
        logic [RW-1:0]    idx;
        logic [CNT_W-1:0] inflight;
        logic [CNT_W-1:0] drop;
    } fst_t;

    fst_t s_q, s_d;
    logic credit_ok;
    logic fire;

    always_comb begin
        s_d       = s_q;
        credit_ok = ({1'b0, occ_i} + {1'b0, s_q.inflight}) < (CNT_W+1)'(DEPTH);
        mem_req_o = s_q.active && !start_i && credit_ok;
        fire      = mem_req_o && mem_gnt_i;
        keep_o    = mem_rvalid_i && (s_q.drop == '0) && !start_i;
        s_d.inflight = s_q.inflight + CNT_W'(fire) - CNT_W'(mem_rvalid_i);
        if (start_i) begin
            // everything still in flight belongs to the old stream
            s_d.drop   = s_q.inflight - CNT_W'(mem_rvalid_i);
            s_d.active = 1'b1;
            s_d.base   = laddr_i;
            s_d.cur    = laddr_i;
            s_d.idx    = '0;
            s_d.len    = RW'(blocks_i) << BL_SH;
        end else begin
            if (mem_rvalid_i && (s_q.drop != '0))
                s_d.drop = s_q.drop - 1'b1;
            if (fire) begin
                if ((s_q.len != '0) && (s_q.idx == s_q.len - 1'b1)) begin
                    s_d.cur = s_q.base;
                    s_d.idx = '0;
                end else begin
                    s_d.cur = s_q.cur + 1'b1;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_addr_o = {s_q.cur, 2'b00};
    assign inflight_o = s_q.inflight;

endmodule

// File: rtl/bstr_buffer.sv
module bstr_buffer
    import bstr_pkg::*;
#(
    parameter int DEPTH   = 16,
    localparam int BYTES  = DEPTH * 4,
    localparam int PTR_W  = $clog2(BYTES),
    localparam int WP_W   = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int AV_W   = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       offset_i,
    input  logic             keep_i,
    input  logic [31:0]      wdata_i,
    input  logic             rd_req_i,
    input  logic [1:0]       rd_size_i,
    output logic             rd_ready_o,
    output logic [31:0]      rd_data_o,
    output logic [CNT_W-1:0] occ_o
);

    typedef struct packed {
        logic [BYTES-1:0][7:0] mem;
        logic [WP_W-1:0]       wr;
        logic [PTR_W-1:0]      rd;
        logic [AV_W-1:0]       avail;
        logic [CNT_W-1:0]      occ;
        logic                  first;
    } bst_t;

    bst_t s_q, s_d;
    logic [2:0]      sz;
    logic            take;
    logic [AV_W-1:0] add_b;
    logic [AV_W-1:0] sub_b;
    logic [2:0]      end_off;
    logic [CNT_W-1:0] freed;

    always_comb begin
        s_d        = s_q;
        sz         = size_bytes(rd_size_i);
        rd_ready_o = (s_q.avail >= AV_W'(sz)) && !start_i;
        take       = rd_req_i && rd_ready_o;
        for (int k = 0; k < 4; k++)
            rd_data_o[8*k +: 8] = (3'(k) < sz) ? s_q.mem[s_q.rd + PTR_W'(k)] : 8'h00;

        add_b   = '0;
        sub_b   = take ? AV_W'(sz) : '0;
        end_off = {1'b0, s_q.rd[1:0]} + sz;
        freed   = take ? CNT_W'(end_off[2]) : '0;

        if (start_i) begin
            s_d.wr    = '0;
            s_d.rd    = {{(PTR_W-2){1'b0}}, offset_i};
            s_d.avail = '0;
            s_d.occ   = '0;
            s_d.first = 1'b1;
        end else begin
            if (keep_i) begin
                for (int k = 0; k < 4; k++)
                    s_d.mem[{s_q.wr, 2'(k)}] = wdata_i[8*k +: 8];
                s_d.wr    = s_q.wr + 1'b1;
                s_d.first = 1'b0;
                // the first word of an unaligned stream holds fewer live bytes
                add_b = s_q.first ? (AV_W'(4) - AV_W'(s_q.rd[1:0])) : AV_W'(4);
            end
            s_d.rd    = s_q.rd + PTR_W'(sub_b);
            s_d.avail = s_q.avail + add_b - sub_b;
            s_d.occ   = s_q.occ + CNT_W'(keep_i) - freed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign occ_o = s_q.occ;

endmodule

// File: rtl/burst_stream_fifo.sv
module burst_stream_fifo #(
    parameter int AW        = 16,
    parameter int DEPTH     = 16,
    parameter int BLK_W     = 4,
    parameter int BLK_LONGS = 16,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    start_addr_i,
    input  logic [BLK_W-1:0] start_blocks_i,
    input  logic             rd_req_i,
    input  logic [1:0]       rd_size_i,
    output logic             rd_ready_o,
    output logic [31:0]      rd_data_o,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [31:0]      mem_rdata_i
);

    logic [CNT_W-1:0] occ_w;
    logic [CNT_W-1:0] inflight_w;
    logic             keep_w;
    logic [1:0]       offset_w;

    // a wrapping region always starts on a word boundary
    assign offset_w = (start_blocks_i == '0) ? start_addr_i[1:0] : 2'b00;

    bstr_fetch #(
        .AW(AW), .DEPTH(DEPTH), .BLK_W(BLK_W), .BLK_LONGS(BLK_LONGS)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .laddr_i(start_addr_i[AW-1:2]), .blocks_i(start_blocks_i),
        .occ_i(occ_w), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
        .keep_o(keep_w), .inflight_o(inflight_w)
    );

    bstr_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_w),
        .keep_i(keep_w), .wdata_i(mem_rdata_i), .rd_req_i(rd_req_i),
        .rd_size_i(rd_size_i), .rd_ready_o(rd_ready_o), .rd_data_o(rd_data_o),
        .occ_o(occ_w)
    );

endmodule

// File: rtl/burst_stream_fifo_chk.sv
module burst_stream_fifo_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_ready_o,
    input logic             mem_req_o,
    input logic             mem_gnt_i,
    input logic [AW-1:0]    mem_addr_o,
    input logic [CNT_W-1:0] occ_i,
    input logic [CNT_W-1:0] inflight_i
);

    // R1: idle while in reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (!mem_req_o && !rd_ready_o));

    // R10: buffer words plus outstanding requests stay within capacity
    a_r10_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ_i} + {1'b0, inflight_i}) <= (CNT_W+1)'(DEPTH));

    // R9: a restart leaves nothing readable in the next cycle
    a_r9_restart_flush: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !rd_ready_o);

    // R11: an ungranted request is held with its address
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i && !start_i) |=>
        (start_i || (mem_req_o && $stable(mem_addr_o))));

endmodule

bind burst_stream_fifo burst_stream_fifo_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_ready_o(rd_ready_o),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o),
    .occ_i(occ_w), .inflight_i(inflight_w)
);

// File: tb/burst_stream_fifo_tb.sv
module burst_stream_fifo_tb;

    localparam int AW    = 16;
    localparam int DEPTH = 16;
    localparam int BLK_W = 4;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [AW-1:0]    start_addr_i;
    logic [BLK_W-1:0] start_blocks_i;
    logic             rd_req_i;
    logic [1:0]       rd_size_i;
    logic             rd_ready_o;
    logic [31:0]      rd_data_o;
    logic             mem_req_o;
    logic [AW-1:0]    mem_addr_o;
    logic             mem_gnt_i;
    logic             mem_rvalid_i;
    logic [31:0]      mem_rdata_i;

    always #2 clk = ~clk;

    burst_stream_fifo #(.AW(AW), .DEPTH(DEPTH), .BLK_W(BLK_W)) u_dut (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected stream state
    int exp_pos, exp_base, exp_len;
    bit wrap_on = 0;
    int region_lo = 0, region_len = 0;
    int g_base, o_base;

    // memory model bookkeeping
    int  grant_cnt, out_cnt, hold_bad;
    logic          pv [LAT];
    logic [AW-1:0] pa [LAT];
    logic          w_q;
    logic [AW-1:0] wa_q;
    int            gcyc;

    function automatic logic [7:0] pat(input int a);
        int b;
        b = a & 16'hffff;
        return 8'((b * 37) + (b >> 8) * 11 + 3);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pv[i] <= 1'b0;
                pa[i] <= '0;
            end
            mem_rvalid_i <= 1'b0;
            mem_rdata_i  <= '0;
            mem_gnt_i    <= 1'b0;
            gcyc         <= 0;
            grant_cnt    <= 0;
            out_cnt      <= 0;
            hold_bad     <= 0;
            w_q          <= 1'b0;
            wa_q         <= '0;
        end else begin
            pv[0] <= mem_req_o && mem_gnt_i;
            pa[0] <= mem_addr_o;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pa[i] <= pa[i-1];
            end
            mem_rvalid_i <= pv[LAT-1];
            mem_rdata_i  <= {pat(int'(pa[LAT-1]) + 3), pat(int'(pa[LAT-1]) + 2),
                             pat(int'(pa[LAT-1]) + 1), pat(int'(pa[LAT-1]))};
            gcyc      <= gcyc + 1;
            mem_gnt_i <= ((gcyc % 3) != 2);
            if (mem_req_o && mem_gnt_i) begin
                grant_cnt <= grant_cnt + 1;
                if (wrap_on && ((int'(mem_addr_o) < region_lo) ||
                                (int'(mem_addr_o) >= region_lo + region_len)))
                    out_cnt <= out_cnt + 1;
            end
            if (w_q && !start_i && !(mem_req_o && (mem_addr_o == wa_q)))
                hold_bad <= hold_bad + 1;
            w_q  <= mem_req_o && !mem_gnt_i && !start_i;
            wa_q <= mem_addr_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic int next_addr(input int a);
        if (exp_len != 0) return exp_base + ((a - exp_base + 1) % exp_len);
        return (a + 1) & 16'hffff;
    endfunction

    // called at a negedge; leaves the bench at a negedge
    task automatic do_start(input int addr, input int blocks);
        start_i        = 1'b1;
        start_addr_i   = AW'(addr);
        start_blocks_i = BLK_W'(blocks);
        rd_req_i       = 1'b1;
        rd_size_i      = 2'd0;
        if (blocks != 0) begin
            exp_pos    = addr & ~3;
            exp_base   = exp_pos;
            exp_len    = blocks * 64;
            region_lo  = exp_pos;
            region_len = exp_len;
            wrap_on    = 1'b1;
        end else begin
            exp_pos = addr;
            exp_len = 0;
            wrap_on = 1'b0;
        end
        #1;
        chk(rd_ready_o == 1'b0, "R9 read refused in restart cycle", rd_ready_o, 0);
        @(negedge clk);
        start_i  = 1'b0;
        rd_req_i = 1'b0;
        g_base   = grant_cnt;
        o_base   = out_cnt;
        #1;
        chk(rd_ready_o == 1'b0, "R9 nothing readable after restart", rd_ready_o, 0);
    endtask

    task automatic do_read(input int code, input string tag);
        int sz, a, guard;
        logic [31:0] expv;
        sz   = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        a    = exp_pos;
        expv = '0;
        for (int k = 0; k < sz; k++) begin
            expv[8*k +: 8] = pat(a);
            a = next_addr(a);
        end
        rd_req_i  = 1'b1;
        rd_size_i = 2'(code);
        #1;
        guard = 0;
        while (!rd_ready_o && guard < 1000) begin
            @(negedge clk);
            #1;
            guard++;
        end
        chk(rd_ready_o == 1'b1, {tag, " read never ready"}, rd_ready_o, 1);
        chk(rd_data_o == expv, tag, rd_data_o, expv);
        exp_pos = a;
        @(negedge clk);
        rd_req_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n          = 1'b0;
        start_i        = 1'b0;
        start_addr_i   = '0;
        start_blocks_i = '0;
        rd_req_i       = 1'b0;
        rd_size_i      = 2'd0;
        repeat (3) @(negedge clk);
        #1;
        chk(rd_ready_o == 1'b0, "R1 ready in reset", rd_ready_o, 0);
        chk(mem_req_o == 1'b0, "R1 request in reset", mem_req_o, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(mem_req_o == 1'b0, "R1 request before first start", mem_req_o, 0);
        chk(rd_ready_o == 1'b0, "R1 ready before first start", rd_ready_o, 0);

        // linear, aligned
        do_start(16'h0100, 0);
        rd_req_i  = 1'b1;
        rd_size_i = 2'd2;
        #1;
        chk(rd_ready_o == 1'b0, "R5 word read before data arrives", rd_ready_o, 0);
        rd_req_i = 1'b0;
        repeat (60) @(negedge clk);
        chk(grant_cnt - g_base == DEPTH, "R10 grants with no reads", grant_cnt - g_base, DEPTH);
        for (int i = 0; i < 120; i++)
            do_read((i * 7 + i / 3) % 4, "R2 R3 R4 R6 linear mixed read");

        // linear, unaligned start
        do_start(16'h0203, 0);
        for (int i = 0; i < 40; i++)
            do_read((i * 5 + 1) % 4, "R4 R5 unaligned linear read");

        // wrapping regions of one to three blocks
        for (int b = 1; b <= 3; b++) begin
            for (int s = 0; s < 2; s++) begin
                do_start(16'h0400 * b + 16'h0040 + s * 16'h0100, b);
                for (int i = 0; i < b * 64 + 20; i++)
                    do_read((i * 3 + i / 5 + s) % 4, "R7 wrapped stream read");
                chk(out_cnt - o_base == 0, "R7 fetch outside region", out_cnt - o_base, 0);
            end
        end

        // wrap with unaligned start address
        do_start(16'h0882, 1);
        for (int i = 0; i < 70; i++)
            do_read((i + i / 4) % 4, "R8 aligned-down wrap read");

        // restart with stale responses in flight
        do_start(16'h3000, 0);
        for (int i = 0; i < 5; i++)
            do_read(2, "R9 before restart");
        do_start(16'h5001, 0);
        for (int i = 0; i < 40; i++)
            do_read((i * 7) % 4, "R9 read after restart");
        do_start(16'h6000, 2);
        do_read(3, "R3 code 3 reads four bytes");
        do_start(16'h7000, 0);
        do_read(0, "R9 restart before any fill");

        chk(hold_bad == 0, "R11 ungranted request dropped or moved", hold_bad, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule